// File: doc/BRIEF.md
# Line-Attached Branch Selector Predictor

This block predicts the direction and kind of branches from state kept beside each instruction cache line. A line covers 64 bytes split into four 16-byte code blocks. Each code block has three shared selectors and nine 2-bit slot pointers. A slot exists only at byte offset 0 and at each odd byte offset. A pointer of 0 means no branch has been seen there. A value of 1 to 3 names the selector that holds the branch kind and its direction state. There is no address tag, so every address with the same line index uses the same line state.

The fetch unit presents a fetch address on the lookup port and gets the prediction one cycle later. When a branch resolves, its last byte address, kind and outcome are written through the update port. A line-invalidate input wipes one line's state when the cache line is replaced.

Both request ports accept a request in every cycle and give no back-pressure. A request counts when its valid is high on a clock edge. The response side also has no ready signal: a result is present for exactly one cycle, and the consumer must take it then.

Top module: `branch_sel_predictor`

## Requirements
- R1: Address fields are offset = bits [3:0], code block = bits [5:4] and line = bits [LINE_W+5:6]. Higher bits are ignored, so aliasing addresses share all state. A later taken or not-taken update through any alias replaces the shared selector's recorded kind.
- R2: Offset 0 maps to slot 0, and an odd offset o maps to slot (o+1)/2. An even nonzero offset has no slot. A lookup there returns not-taken with selector 0 and kind 0, and an update there changes no state.
- R3: rsp_valid is high exactly in the cycle after a cycle with lk_valid high. While rsp_valid is low, rsp_taken, rsp_sel and rsp_kind are 0.
- R4: rsp_sel 0 means the slot has no selector, and it comes with not-taken and kind 0. A not-taken update to a slot with no selector allocates nothing.
- R5: A taken update to a slot with no selector allocates the code block's selectors in the order 0, 1, 2, 0, ... and reports each as rsp_sel = index+1. The new selector records the update kind (0 conditional, 1 jump, 2 call, 3 return) in always mode, so it predicts taken.
- R6: An update to a slot with a selector steps that selector as follows:
  - always mode: not-taken moves it to dynamic with counter 2.
  - dynamic mode: taken raises the counter, or moves it to always mode from 3. Not-taken lowers the counter, or moves it to never mode from 0.
  - never mode: taken moves it to dynamic with counter 1.
  - Prediction: always gives taken, never gives not-taken, and dynamic gives taken when the counter is 2 or 3.
- R7: When a selector is reused by allocation, every slot of that code block that pointed at it, other than the new one, is cleared to 0.
- R8: inv_valid clears all slots and selectors of line inv_line and restarts its allocation order at selector 0. Other lines keep their state.
- R9: A lookup sees the state after the update and the invalidate given in the same cycle. When an update and an invalidate hit the same line in one cycle, the invalidate wins.
- R10: After reset every lookup returns not-taken with selector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch byte address to predict |
| rsp_valid | output | 1 | Lookup result present |
| rsp_taken | output | 1 | Predicted taken |
| rsp_kind | output | 2 | Recorded branch kind |
| rsp_sel | output | 2 | Selector used (0 = none, 1 to 3) |
| up_valid | input | 1 | Resolved branch update |
| up_addr | input | ADDR_W | Byte address of the branch's last byte |
| up_kind | input | 2 | Branch kind of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| inv_valid | input | 1 | Line invalidate request |
| inv_line | input | LINE_W | Line index to clear, LINE_W = log2(NUM_LINES) |

## Verification
The hardest state to reach is selector reuse in a code block where several slots already point at different selectors. That state is also needed to see a stale pointer cleared while the other pointers survive. The bench gets there by sending taken updates to every byte offset of one code block in turn. After each update it looks up all sixteen offsets and compares them against an arithmetic model. That pushes the allocation order through three full wraps. Aliased addresses and same-cycle update, invalidate and lookup combinations drive the shared-state and priority cases.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int BLK_BYTES  = 16;
  localparam int BLKS       = 4;
  localparam int SELS       = 3;
  localparam int SLOTS      = 9;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int PTR_W      = 2;

  typedef enum logic [1:0] {
    BK_COND = 2'd0,
    BK_JUMP = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    PM_NEVER  = 2'd0,
    PM_ALWAYS = 2'd1,
    PM_DYN    = 2'd2
  } pmode_e;

  typedef struct packed {
    logic     vld;
    br_kind_e kind;
    pmode_e   mode;
    logic [1:0] ctr;
  } sel_t;

  // a slot exists at byte 0 and at every odd byte
  function automatic logic slot_exists(input logic [3:0] off);
    return (off == 4'd0) || off[0];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_index(input logic [3:0] off);
    if (off == 4'd0) return '0;
    return SLOT_W'({1'b0, off[3:1]}) + SLOT_W'(1);
  endfunction

  function automatic logic predict(input sel_t s);
    return (s.mode == PM_ALWAYS) || (s.mode == PM_DYN && s.ctr[1]);
  endfunction
endpackage

// File: rtl/bsel_addr_map.sv
module bsel_addr_map
  import bsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LINE_W-1:0] line,
  output logic [1:0]        blk,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_ok
);
  logic unused_hi;
  assign unused_hi = ^addr[ADDR_W-1:LINE_W+6];

  assign line    = addr[LINE_W+5:6];
  assign blk     = addr[5:4];
  assign slot    = slot_index(addr[3:0]);
  assign slot_ok = slot_exists(addr[3:0]);
endmodule

// File: rtl/bsel_sel_step.sv
module bsel_sel_step
  import bsel_pkg::*;
(
  input  sel_t     cur,
  input  br_kind_e kind,
  input  logic     taken,
  output sel_t     nxt
);
  always_comb begin
    nxt      = cur;
    nxt.kind = kind;
    case (cur.mode)
      PM_ALWAYS: begin
        if (!taken) begin
          nxt.mode = PM_DYN;
          nxt.ctr  = 2'd2;
        end
      end
      PM_NEVER: begin
        if (taken) begin
          nxt.mode = PM_DYN;
          nxt.ctr  = 2'd1;
        end
      end
      default: begin
        if (taken) begin
          if (cur.ctr == 2'd3) nxt.mode = PM_ALWAYS;
          else                 nxt.ctr  = cur.ctr + 2'd1;
        end else begin
          if (cur.ctr == 2'd0) nxt.mode = PM_NEVER;
          else                 nxt.ctr  = cur.ctr - 2'd1;
        end
      end
    endcase
  end
endmodule

// File: rtl/bsel_block.sv
module bsel_block
  import bsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] upd_slot,
  input  br_kind_e          upd_kind,
  input  logic              upd_taken,
  input  logic              inv_en,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic              rd_ok,
  output logic              rd_taken,
  output logic [1:0]        rd_kind,
  output logic [1:0]        rd_sel
);
  logic [1:0]       ind_q [SLOTS];
  logic [1:0]       ind_n [SLOTS];
  sel_t             sel_q [SELS];
  sel_t             sel_n [SELS];
  sel_t             stepped [SELS];
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [1:0]       cur_ind;
  logic [1:0]       rd_ind;

  for (genvar k = 0; k < SELS; k++) begin : g_step
    bsel_sel_step u_step (
      .cur   (sel_q[k]),
      .kind  (upd_kind),
      .taken (upd_taken),
      .nxt   (stepped[k])
    );
  end

  assign cur_ind = ind_q[upd_slot];

  always_comb begin
    ind_n = ind_q;
    sel_n = sel_q;
    ptr_n = ptr_q;
    if (upd_en) begin
      if (cur_ind != 2'd0) begin
        for (int k = 0; k < SELS; k++)
          if (cur_ind == 2'(k + 1)) sel_n[k] = stepped[k];
      end else if (upd_taken) begin
        for (int s = 0; s < SLOTS; s++)
          if (ind_q[s] == ptr_q + 2'd1) ind_n[s] = 2'd0;
        ind_n[upd_slot] = ptr_q + 2'd1;
        for (int k = 0; k < SELS; k++)
          if (ptr_q == PTR_W'(k)) begin
            sel_n[k].vld  = 1'b1;
            sel_n[k].kind = upd_kind;
            sel_n[k].mode = PM_ALWAYS;
            sel_n[k].ctr  = 2'd3;
          end
        ptr_n = (ptr_q == PTR_W'(SELS - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
    end
    if (inv_en) begin
      for (int s = 0; s < SLOTS; s++) ind_n[s] = 2'd0;
      for (int k = 0; k < SELS; k++)  sel_n[k] = '0;
      ptr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) ind_q[s] <= 2'd0;
      for (int k = 0; k < SELS; k++)  sel_q[k] <= '0;
      ptr_q <= '0;
    end else begin
      ind_q <= ind_n;
      sel_q <= sel_n;
      ptr_q <= ptr_n;
    end
  end

  // lookups observe the state after this cycle's update and invalidate
  assign rd_ind = rd_ok ? ind_n[rd_slot] : 2'd0;

  always_comb begin
    rd_taken = 1'b0;
    rd_kind  = 2'd0;
    rd_sel   = 2'd0;
    for (int k = 0; k < SELS; k++)
      if (rd_ind == 2'(k + 1)) begin
        rd_taken = predict(sel_n[k]);
        rd_kind  = sel_n[k].kind;
        rd_sel   = rd_ind;
      end
  end
endmodule

// File: rtl/branch_sel_predictor.sv
module branch_sel_predictor
  import bsel_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic [1:0]        rsp_kind,
  output logic [1:0]        rsp_sel,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [1:0]        up_kind,
  input  logic              up_taken,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line
);
  localparam int NBLK  = NUM_LINES * BLKS;
  localparam int IDX_W = LINE_W + 2;

  logic [LINE_W-1:0] lk_line, up_line;
  logic [1:0]        lk_blk, up_blk;
  logic [SLOT_W-1:0] lk_slot, up_slot;
  logic              lk_ok, up_ok;

  bsel_addr_map #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_lk_map (
    .addr(lk_addr), .line(lk_line), .blk(lk_blk), .slot(lk_slot), .slot_ok(lk_ok)
  );
  bsel_addr_map #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_up_map (
    .addr(up_addr), .line(up_line), .blk(up_blk), .slot(up_slot), .slot_ok(up_ok)
  );

  logic       rd_t [NBLK];
  logic [1:0] rd_k [NBLK];
  logic [1:0] rd_s [NBLK];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic inv_hit;
    assign inv_hit = inv_valid && (inv_line == LINE_W'(l));
    for (genvar b = 0; b < BLKS; b++) begin : g_blk
      logic upd_hit;
      assign upd_hit = up_valid && up_ok && (up_line == LINE_W'(l)) && (up_blk == 2'(b));
      bsel_block u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_hit),
        .upd_slot  (up_slot),
        .upd_kind  (br_kind_e'(up_kind)),
        .upd_taken (up_taken),
        .inv_en    (inv_hit),
        .rd_slot   (lk_slot),
        .rd_ok     (lk_ok),
        .rd_taken  (rd_t[l*BLKS+b]),
        .rd_kind   (rd_k[l*BLKS+b]),
        .rd_sel    (rd_s[l*BLKS+b])
      );
    end
  end

  logic [IDX_W-1:0] lk_idx;
  assign lk_idx = {lk_line, lk_blk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_kind  <= 2'd0;
      rsp_sel   <= 2'd0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_taken <= lk_valid && rd_t[lk_idx];
      rsp_kind  <= lk_valid ? rd_k[lk_idx] : 2'd0;
      rsp_sel   <= lk_valid ? rd_s[lk_idx] : 2'd0;
    end
  end
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              rsp_valid,
  input logic              rsp_taken,
  input logic [1:0]        rsp_kind,
  input logic [1:0]        rsp_sel,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_taken,
  input logic              inv_valid,
  input logic [LINE_W-1:0] inv_line
);
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R3
  AST_RESP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_taken && rsp_sel == 2'd0 && rsp_kind == 2'd0)); // R3
  AST_NO_SLOT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_addr[3:0] != 4'd0 && !lk_addr[0])
      |=> (!rsp_taken && rsp_sel == 2'd0 && rsp_kind == 2'd0)); // R2
  AST_EMPTY_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_sel == 2'd0) |-> (!rsp_taken && rsp_kind == 2'd0)); // R4
  AST_INV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && inv_valid && inv_line == lk_addr[LINE_W+5:6])
      |=> (!rsp_taken && rsp_sel == 2'd0)); // R9
  AST_TAKEN_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && up_valid && up_taken && lk_addr[LINE_W+5:0] == up_addr[LINE_W+5:0]
     && (up_addr[3:0] == 4'd0 || up_addr[0])
     && !(inv_valid && inv_line == up_addr[LINE_W+5:6]))
      |=> (rsp_sel != 2'd0)); // R5
endmodule

bind branch_sel_predictor bsel_checker #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/branch_sel_predictor_test.sv
module branch_sel_predictor_test;
  localparam int AW = 32;
  localparam int NL = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rsp_valid, rsp_taken;
  logic [1:0]    rsp_kind, rsp_sel;
  logic          up_valid = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [1:0]    up_kind = '0;
  logic          up_taken = 1'b0;
  logic          inv_valid = 1'b0;
  logic [LW-1:0] inv_line = '0;

  always #10 clk = ~clk;

  branch_sel_predictor #(.ADDR_W(AW), .NUM_LINES(NL)) uut (.*);

  int checks = 0;
  int errors = 0;

  // model: mode 0 never, 1 always, 2 dynamic
  int m_ind  [NL][4][9];
  int m_kind [NL][4][3];
  int m_mode [NL][4][3];
  int m_ctr  [NL][4][3];
  int m_ptr  [NL][4];

  function automatic void m_clear(int l);
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 9; s++) m_ind[l][b][s] = 0;
      for (int k = 0; k < 3; k++) begin
        m_kind[l][b][k] = 0; m_mode[l][b][k] = 0; m_ctr[l][b][k] = 0;
      end
      m_ptr[l][b] = 0;
    end
  endfunction

  function automatic int f_line(logic [AW-1:0] a); return int'(a[8:6]); endfunction
  function automatic int f_blk(logic [AW-1:0] a);  return int'(a[5:4]); endfunction
  function automatic int f_slot(logic [AW-1:0] a); // -1: no slot
    int o = int'(a[3:0]);
    if (o == 0) return 0;
    if (o % 2 == 1) return (o + 1) / 2;
    return -1;
  endfunction

  function automatic void m_update(logic [AW-1:0] a, int kd, bit t);
    int l = f_line(a), b = f_blk(a), s = f_slot(a), i, v;
    if (s < 0) return;
    i = m_ind[l][b][s];
    if (i == 0) begin
      if (!t) return;
      v = m_ptr[l][b];
      for (int x = 0; x < 9; x++) if (m_ind[l][b][x] == v + 1) m_ind[l][b][x] = 0;
      m_ind[l][b][s] = v + 1;
      m_kind[l][b][v] = kd; m_mode[l][b][v] = 1; m_ctr[l][b][v] = 3;
      m_ptr[l][b] = (v + 1) % 3;
    end else begin
      v = i - 1;
      m_kind[l][b][v] = kd;
      case (m_mode[l][b][v])
        1: if (!t) begin m_mode[l][b][v] = 2; m_ctr[l][b][v] = 2; end
        0: if (t)  begin m_mode[l][b][v] = 2; m_ctr[l][b][v] = 1; end
        default: begin
          if (t) begin
            if (m_ctr[l][b][v] == 3) m_mode[l][b][v] = 1; else m_ctr[l][b][v]++;
          end else begin
            if (m_ctr[l][b][v] == 0) m_mode[l][b][v] = 0; else m_ctr[l][b][v]--;
          end
        end
      endcase
    end
  endfunction

  task automatic cyc(input bit lv, input logic [AW-1:0] la,
                     input bit uv, input logic [AW-1:0] ua, input int uk, input bit ut,
                     input bit iv, input int il, input string req);
    int l, b, s, i, et, ek, es;
    lk_valid = lv; lk_addr = la;
    up_valid = uv; up_addr = ua; up_kind = 2'(uk); up_taken = ut;
    inv_valid = iv; inv_line = LW'(il);
    @(posedge clk);
    if (uv) m_update(ua, uk, ut);
    if (iv) m_clear(il);
    @(negedge clk);
    et = 0; ek = 0; es = 0;
    if (lv) begin
      l = f_line(la); b = f_blk(la); s = f_slot(la);
      i = (s < 0) ? 0 : m_ind[l][b][s];
      if (i != 0) begin
        es = i;
        ek = m_kind[l][b][i-1];
        et = (m_mode[l][b][i-1] == 1 || (m_mode[l][b][i-1] == 2 && m_ctr[l][b][i-1] >= 2)) ? 1 : 0;
      end
    end
    checks++;
    if (rsp_valid !== lv || int'(rsp_taken) != et || int'(rsp_sel) != es || int'(rsp_kind) != ek) begin
      errors++;
      $display("FAIL %s addr=%h got v=%0b t=%0b sel=%0d kind=%0d exp v=%0b t=%0d sel=%0d kind=%0d",
               req, la, rsp_valid, rsp_taken, rsp_sel, rsp_kind, lv, et, es, ek);
    end
    lk_valid = 1'b0; up_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input string req);
    cyc(1, a, 0, '0, 0, 0, 0, 0, req);
  endtask

  task automatic update(input logic [AW-1:0] a, input int kd, input bit t, input string req);
    cyc(0, '0, 1, a, kd, t, 0, 0, req);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int l = 0; l < NL; l++) m_clear(l);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R3 idle outputs
    for (int o = 0; o < 64; o++) lookup(32'(o), "R10");
    cyc(0, '0, 0, '0, 0, 0, 0, 0, "R3 idle");

    // R4 not-taken updates allocate nothing; R2 even offsets
    for (int o = 0; o < 16; o++) begin
      update(32'(2*64 + 16 + o), 1, 0, "R4");
      lookup(32'(2*64 + 16 + o), "R4 R2");
    end

    // R5 R7 R2: taken update at each offset, full block swept after each
    for (int u = 0; u < 16; u++) begin
      update(32'(3*64 + u), u % 4, 1, "R5 R2");
      for (int o = 0; o < 16; o++) lookup(32'(3*64 + o), "R5 R7 R2");
    end
    // second pass exercises R6 on surviving selectors
    for (int u = 15; u >= 0; u--) begin
      update(32'(3*64 + u), (u + 1) % 4, u[1], "R6");
      for (int o = 0; o < 16; o++) lookup(32'(3*64 + o), "R6 R7");
    end

    // R6 mode walk on one slot
    begin
      logic [23:0] pat = 24'b1000_0000_0111_1100_1010_0011;
      for (int n = 0; n < 24; n++) begin
        update(32'(5*64 + 16 + 7), 0, pat[n], "R6");
        lookup(32'(5*64 + 16 + 7), "R6");
      end
    end

    // R1 aliasing through high address bits
    update(32'h0000_0183, 2, 1, "R1");
    lookup(32'h0000_1383, "R1");
    update(32'h0005_0383, 3, 0, "R1");
    lookup(32'h0000_0183, "R1");
    lookup(32'hFFFF_FF83, "R1");

    // R8 invalidate: line 3 cleared, other lines kept
    cyc(0, '0, 0, '0, 0, 0, 1, 3, "R8");
    for (int o = 0; o < 64; o++) lookup(32'(3*64 + o), "R8");
    lookup(32'h0000_0183, "R8 other line");
    lookup(32'(5*64 + 16 + 7), "R8 other line");
    update(32'(3*64 + 32 + 9), 1, 1, "R8 order restart");
    lookup(32'(3*64 + 32 + 9), "R8 order restart");

    // R9 same-cycle priority
    cyc(1, 32'(4*64 + 5), 1, 32'(4*64 + 5), 2, 1, 0, 0, "R9 update first");
    cyc(1, 32'(4*64 + 7), 1, 32'(4*64 + 7), 1, 1, 1, 4, "R9 invalidate wins");
    lookup(32'(4*64 + 5), "R9");
    lookup(32'(4*64 + 7), "R9");
    cyc(1, 32'(6*64 + 3), 1, 32'(6*64 + 3), 3, 1, 1, 2, "R9 other line inv");
    cyc(1, 32'(6*64 + 3), 1, 32'(6*64 + 3), 3, 0, 0, 0, "R9 step seen");

    finish_run();
  end
endmodule